// File: doc/BRIEF.md
# Output-Buffer Flag and Interrupt Arbiter for a Two-Channel Input Controller

This block sits between two byte-producing input channels (a keyboard channel and an auxiliary pointing-device channel) and the host side of an input controller. Each channel raises a level while it holds a byte for the host. From these two levels and the controller's configuration byte, the block produces several registered outputs. The first is the buffer-full flag that the host polls. The second is a copy of that flag on the controller's general output port. The third is a flag that says the waiting byte came from the auxiliary channel. The last two are one interrupt request line per channel.

When the host reads the data port, the block decides which channel supplies the byte. For one clock it raises a grant pulse toward that channel's queue. Keyboard data always wins. The auxiliary channel is flagged, interrupts, and is granted a read only when it is the sole channel holding data.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge, so the interrupt lines are glitch-free levels that follow every change of a pending level or of the configuration byte.

Top module: `obf_irq_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0.
- R2: The status buffer-full flag and the output-port buffer-full copy are 1 in the cycle after either pending input was 1, and 0 otherwise.
- R3: The status auxiliary flag and its output-port copy are 1 in the cycle after the auxiliary pending input was 1 while the keyboard pending input was 0, and 0 in every other case.
- R4: The keyboard interrupt is 1 in the cycle after keyboard data was pending, with configuration bit 0 (keyboard interrupt enable) at 1 and configuration bit 4 (keyboard disable) at 0.
- R5: The auxiliary interrupt is 1 in the cycle after the auxiliary-only condition of R3 held with configuration bit 1 (auxiliary interrupt enable) at 1. Keyboard data pending suppresses it.
- R6: A read strobe produces, in the next cycle only, exactly one grant pulse. The pulse goes to the auxiliary queue when only the auxiliary channel was pending, and to the keyboard queue otherwise, including when nothing was pending.
- R7: A change of the configuration byte alone, with pending levels steady, updates both interrupt lines in the next cycle. The buffer-full and auxiliary flags do not change.
- R8: Configuration bits other than 0, 1 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_avail | input | 1 | Keyboard channel holds a byte |
| aux_avail | input | 1 | Auxiliary channel holds a byte |
| cfg | input | 8 | Configuration byte (bit 0 kbd irq enable, bit 1 aux irq enable, bit 4 kbd disable) |
| rd_strobe | input | 1 | Host read of the data port |
| stat_full | output | 1 | Status: output buffer full |
| stat_aux | output | 1 | Status: buffered byte is from the auxiliary channel |
| port_full | output | 1 | Output-port copy of the buffer-full flag |
| port_aux | output | 1 | Output-port copy of the auxiliary flag |
| kbd_irq | output | 1 | Keyboard interrupt request level |
| aux_irq | output | 1 | Auxiliary interrupt request level |
| grant_kbd | output | 1 | One-cycle pulse: read taken from keyboard queue |
| grant_aux | output | 1 | One-cycle pulse: read taken from auxiliary queue |

## Verification
Several properties are checked on every cycle. The buffer-full flag follows the OR of the previous pending levels, and the auxiliary flag never appears without buffer-full or beside a keyboard interrupt. The port copies always equal the status flags. Each strobe yields exactly one grant. Whether a particular configuration byte gates the right interrupt, that ignored configuration bits leave everything unchanged, and that an empty buffer still grants the keyboard side can only be shown by the bench's chosen input sequences compared against its scoreboard.

// File: rtl/obf_irq_arbiter.sv
`timescale 1ns/1ps
module obf_irq_arbiter #(
  parameter int CFG_W       = 8,
  parameter int KIRQ_EN_BIT = 0,
  parameter int AIRQ_EN_BIT = 1,
  parameter int KDIS_BIT    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kbd_avail,
  input  logic             aux_avail,
  input  logic [CFG_W-1:0] cfg,
  input  logic             rd_strobe,
  output logic             stat_full,
  output logic             stat_aux,
  output logic             port_full,
  output logic             port_aux,
  output logic             kbd_irq,
  output logic             aux_irq,
  output logic             grant_kbd,
  output logic             grant_aux
);

  logic [1:0] pend;
  logic       aux_only;
  logic       full_q, aux_q, kirq_q, airq_q, gk_q, ga_q;

  assign pend     = {aux_avail, kbd_avail};
  assign aux_only = (pend == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      aux_q  <= 1'b0;
      kirq_q <= 1'b0;
      airq_q <= 1'b0;
      gk_q   <= 1'b0;
      ga_q   <= 1'b0;
    end else begin
      full_q <= |pend;
      aux_q  <= aux_only;
      kirq_q <= pend[0] & cfg[KIRQ_EN_BIT] & ~cfg[KDIS_BIT];
      airq_q <= aux_only & cfg[AIRQ_EN_BIT];
      gk_q   <= rd_strobe & ~aux_only;
      ga_q   <= rd_strobe & aux_only;
    end
  end

  assign stat_full = full_q;
  assign port_full = full_q;
  assign stat_aux  = aux_q;
  assign port_aux  = aux_q;
  assign kbd_irq   = kirq_q;
  assign aux_irq   = airq_q;
  assign grant_kbd = gk_q;
  assign grant_aux = ga_q;

endmodule

// File: rtl/obf_irq_arbiter_chk.sv
`timescale 1ns/1ps
module obf_irq_arbiter_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kbd_avail,
  input logic             aux_avail,
  input logic [CFG_W-1:0] cfg,
  input logic             rd_strobe,
  input logic             stat_full,
  input logic             stat_aux,
  input logic             port_full,
  input logic             port_aux,
  input logic             kbd_irq,
  input logic             aux_irq,
  input logic             grant_kbd,
  input logic             grant_aux
);

  // R2
  full_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_full == ($past(kbd_avail) | $past(aux_avail))));

  // R2
  port_full_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_full == stat_full);

  // R3
  port_aux_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_aux == stat_aux);

  // R3
  aux_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_aux |-> stat_full);

  // R5
  aux_irq_needs_aux_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> stat_aux);

  // R4
  kbd_irq_excludes_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> (stat_full && !stat_aux));

  // R6
  one_grant_per_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> $onehot({grant_kbd, grant_aux}));

  // R6
  no_stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !(grant_kbd || grant_aux));

endmodule

bind obf_irq_arbiter obf_irq_arbiter_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/tb_obf_irq_arbiter.sv
`timescale 1ns/1ps
module tb_obf_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_avail = 1'b0, aux_avail = 1'b0, rd_strobe = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic stat_full, stat_aux, port_full, port_aux, kbd_irq, aux_irq, grant_kbd, grant_aux;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  obf_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .kbd_avail(kbd_avail), .aux_avail(aux_avail),
    .cfg(cfg), .rd_strobe(rd_strobe),
    .stat_full(stat_full), .stat_aux(stat_aux), .port_full(port_full), .port_aux(port_aux),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq), .grant_kbd(grant_kbd), .grant_aux(grant_aux));

  function automatic logic [7:0] observed();
    return {grant_aux, grant_kbd, aux_irq, kbd_irq, port_aux, port_full, stat_aux, stat_full};
  endfunction

  task automatic step(input logic k, input logic a, input logic [7:0] c, input logic rd, input string tag);
    logic alone;
    logic [7:0] e;
    @(negedge clk);
    kbd_avail = k; aux_avail = a; cfg = c; rd_strobe = rd;
    alone = a & ~k;
    e[0] = k | a;
    e[1] = alone;
    e[2] = k | a;
    e[3] = alone;
    e[4] = k & c[0] & ~c[4];
    e[5] = alone & c[1];
    e[6] = rd & ~alone;
    e[7] = rd & alone;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (observed() !== e) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", t, observed(), e);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    kbd_avail = 1'b1; aux_avail = 1'b1; cfg = 8'hFF; rd_strobe = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== 8'h00) begin
      errors++;
      $display("FAIL R1 actual=%b expected=%b", observed(), 8'h00);
    end
    kbd_avail = 1'b0; aux_avail = 1'b0; cfg = 8'h00; rd_strobe = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (observed() !== 8'h00) begin
      errors++;
      $display("FAIL R1 actual=%b expected=%b", observed(), 8'h00);
    end

    step(0, 0, 8'h03, 0, "R2 idle");
    step(1, 0, 8'h03, 0, "R2 R4 kbd only");
    step(1, 1, 8'h03, 0, "R3 R5 both pending kbd wins");
    step(0, 1, 8'h03, 0, "R3 R5 aux only");
    step(0, 1, 8'h01, 0, "R7 aux irq disabled");
    step(0, 1, 8'h03, 0, "R7 aux irq enabled");
    step(1, 0, 8'h13, 0, "R4 kbd disabled");
    step(1, 0, 8'h03, 0, "R7 kbd re-enabled");
    step(1, 0, 8'h02, 0, "R4 kbd irq enable off");
    step(1, 0, 8'hEF, 0, "R8 unused bits set");
    step(0, 1, 8'hEC, 0, "R8 aux unused bits");
    step(0, 1, 8'h03, 1, "R6 read aux only");
    step(1, 1, 8'h03, 1, "R6 read both");
    step(1, 0, 8'h03, 1, "R6 read kbd");
    step(0, 0, 8'h03, 1, "R6 read empty");
    step(0, 0, 8'h03, 0, "R6 no read no grant");
    step(1, 1, 8'h13, 1, "R4 R6 disabled kbd still read");
    step(0, 0, 8'hFF, 0, "R2 R8 empty all cfg");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule